// File: doc/BRIEF.md
# Voting Reset and Power-Cycle Resolver

This block arbitrates restart actions among three redundant processors. Every clock, each processor presents a 2-bit action code and a 2-bit target code. From these the block drives one reset line and one power-enable line per processor. It also raises a per-processor flag that tells nearby logic the processor is not taking part in votes.

A processor acting alone may restart itself or the whole group. It cannot act alone on another single processor. An action against any other processor needs a second, distinct processor voting the same action against the same target.

Power restoration is closed-loop rather than timed. After a processor's supply is switched off, power returns only when two conditions hold together: the cycle request has gone, and that processor's current-off flag reports that its supply current has collapsed. An overcurrent fault input removes power at once, without waiting for a clock edge.

Top module: `voting_resolver`

Action codes: 00 = offline (not voting), 11 = online with no request, 01 = vote reset, 10 = vote power-cycle.

Target codes for processor i: 00 = itself, 01 = the next processor ((i+1) mod 3), 10 = both other processors, 11 = all processors.

Processor i uses bits [2i+1:2i] of `req_code_i` and of `tgt_sel_i`, and bit i of every 1-bit-per-processor port.

## Requirements
- R1: On each clock edge, `no_vote_o[i]` is loaded high if processor i's action code is 00 and low for any other code.
- R2: Action code 01 with target 11 from any single processor asserts `proc_reset_o` on every powered processor at the next edge.
- R3: Action code 10 with target 00 from a single processor drops that processor's `proc_power_o` at the next edge.
- R4: Action code 01 with target 00 (reset of self) is taken as power-cycle of all processors: every `proc_power_o` drops at the next edge.
- R5: A single peer vote against a processor (target 01 or 10) has no effect. One reset vote and one cycle vote against the same target also have no effect.
- R6: When two distinct processors vote the same action (reset or cycle) against the same target through target 01 or 10, that action is applied to the target at the next edge.
- R7: `proc_reset_o[i]` is high for each cycle following an edge at which a reset was granted to processor i. It is low in the cycle after the first edge without a grant.
- R8: A processor whose power is off gets power back only at an edge where it has no cycle grant and `curr_off_i[i]` is high. Otherwise it stays off.
- R9: `overcur_i[i]` high drives `proc_power_o[i]` low immediately, without a clock edge, and keeps it low while the fault stays high.
- R10: A processor that is powered off never has `proc_reset_o` asserted; reset grants to it are ignored.
- R11: If a processor is granted both reset and cycle at the same edge, only the power-cycle takes effect.
- R12: While `rst_n` is low at a clock edge, all reset outputs go low, all power enables go high and all `no_vote_o` bits go high.
- R13: Action codes 00 and 11 cast no vote and trigger no action, whatever the target code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_code_i | input | 2*N_PROC | Per-processor action code |
| tgt_sel_i | input | 2*N_PROC | Per-processor target code |
| overcur_i | input | N_PROC | Overcurrent fault, forces power off asynchronously |
| curr_off_i | input | N_PROC | Supply current has fallen below the off threshold |
| proc_reset_o | output | N_PROC | Reset line to each processor |
| proc_power_o | output | N_PROC | Power switch enable for each processor |
| no_vote_o | output | N_PROC | Processor is offline and must not be counted as a voter |

## Verification
The bound checker watches several behaviours on every cycle:
- an overcurrent fault always coincides with power off;
- power never returns without the current-off flag seen at the previous edge;
- a processor kept off shows no reset;
- a reset rises only after a reset grant;
- a cycle grant leaves reset low;
- the not-voting flag follows the previous action code.

Only the bench scenarios can show the voting arithmetic itself. These cover:
- that one peer vote does nothing and two matching votes act;
- that mixed reset and cycle votes do not add up;
- that reset-of-self is turned into power-cycle-all;
- that a reset request aimed at everyone spares unpowered processors.

// File: rtl/resolver_pkg.sv
// Shared encodings for the voting reset/power-cycle resolver.
// Assumes two-bit action and target fields per processor.
package resolver_pkg;

    // Action code presented by each processor.
    typedef enum logic [1:0] {
        ACT_OFFLINE = 2'b00,
        ACT_RESET   = 2'b01,
        ACT_CYCLE   = 2'b10,
        ACT_IDLE    = 2'b11
    } act_code_e;

    // Target code, relative to the requesting processor.
    typedef enum logic [1:0] {
        TGT_SELF  = 2'b00,
        TGT_NEXT  = 2'b01,
        TGT_PEERS = 2'b10,
        TGT_ALL   = 2'b11
    } tgt_code_e;

endpackage

// File: rtl/req_decoder.sv
// Turns one processor's action and target codes into four target masks:
// immediate reset, immediate power-cycle, reset vote and cycle vote.
// Assumes IDX is this requester's position; the next peer is (IDX+1) mod N_PROC.
module req_decoder
    import resolver_pkg::*;
#(
    parameter int N_PROC = 3,
    parameter int IDX    = 0
) (
    input  logic [1:0]        act_i,
    input  logic [1:0]        tgt_i,
    output logic [N_PROC-1:0] rst_now_o,
    output logic [N_PROC-1:0] cyc_now_o,
    output logic [N_PROC-1:0] rst_vote_o,
    output logic [N_PROC-1:0] cyc_vote_o
);

    localparam int              NEXT_IDX = (IDX + 1) % N_PROC;
    localparam logic [N_PROC-1:0] SELF_M = N_PROC'(1) << IDX;
    localparam logic [N_PROC-1:0] NEXT_M = N_PROC'(1) << NEXT_IDX;
    localparam logic [N_PROC-1:0] ALL_M  = {N_PROC{1'b1}};
    localparam logic [N_PROC-1:0] PEER_M = ALL_M & ~SELF_M;

    // Decode the request into immediate actions and peer votes.
    always_comb begin
        rst_now_o  = '0;
        cyc_now_o  = '0;
        rst_vote_o = '0;
        cyc_vote_o = '0;
        case (act_i)
            ACT_RESET: begin
                case (tgt_i)
                    TGT_SELF:  cyc_now_o  = ALL_M;   // reset-of-self means cycle everyone
                    TGT_ALL:   rst_now_o  = ALL_M;
                    TGT_NEXT:  rst_vote_o = NEXT_M;
                    TGT_PEERS: rst_vote_o = PEER_M;
                    default:   rst_vote_o = '0;
                endcase
            end
            ACT_CYCLE: begin
                case (tgt_i)
                    TGT_SELF:  cyc_now_o  = SELF_M;
                    TGT_ALL:   cyc_now_o  = ALL_M;
                    TGT_NEXT:  cyc_vote_o = NEXT_M;
                    TGT_PEERS: cyc_vote_o = PEER_M;
                    default:   cyc_vote_o = '0;
                endcase
            end
            default: begin
                rst_now_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/vote_tally.sv
// Combines the masks of all requesters into one reset grant and one
// cycle grant per target. Voter k's masks sit at bits [k*N_PROC +: N_PROC].
// Assumes each voter sets at most one bit per target, so distinct voters are counted.
module vote_tally #(
    parameter int N_PROC   = 3,
    parameter int VOTE_MIN = 2
) (
    input  logic [N_PROC*N_PROC-1:0] rst_now_i,
    input  logic [N_PROC*N_PROC-1:0] cyc_now_i,
    input  logic [N_PROC*N_PROC-1:0] rst_vote_i,
    input  logic [N_PROC*N_PROC-1:0] cyc_vote_i,
    output logic [N_PROC-1:0]        go_reset_o,
    output logic [N_PROC-1:0]        go_cycle_o
);

    localparam int CNT_W = $clog2(N_PROC + 1);
    localparam logic [CNT_W-1:0] NEED = CNT_W'(VOTE_MIN);

    for (genvar t = 0; t < N_PROC; t++) begin : g_tgt
        logic [CNT_W-1:0] n_rst;
        logic [CNT_W-1:0] n_cyc;
        logic             imm_rst;
        logic             imm_cyc;

        // Count peer votes and gather immediate requests aimed at target t.
        always_comb begin
            n_rst   = '0;
            n_cyc   = '0;
            imm_rst = 1'b0;
            imm_cyc = 1'b0;
            for (int k = 0; k < N_PROC; k++) begin
                n_rst   = n_rst + CNT_W'(rst_vote_i[k*N_PROC + t]);
                n_cyc   = n_cyc + CNT_W'(cyc_vote_i[k*N_PROC + t]);
                imm_rst = imm_rst | rst_now_i[k*N_PROC + t];
                imm_cyc = imm_cyc | cyc_now_i[k*N_PROC + t];
            end
        end

        assign go_reset_o[t] = imm_rst | (n_rst >= NEED);
        assign go_cycle_o[t] = imm_cyc | (n_cyc >= NEED);
    end

endmodule

// File: rtl/proc_restart_fsm.sv
// Per-processor restart state: a one-bit reset machine (running/resetting)
// and a one-bit power machine (on/off). An overcurrent fault clears the
// power bit asynchronously. Power returns only on the current-off flag
// with no cycle grant pending. Reset is held off while power is off.
module proc_restart_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic go_reset_i,
    input  logic go_cycle_i,
    input  logic fault_i,
    input  logic isoff_i,
    output logic rst_o,
    output logic pwr_o
);

    logic pwr_q;
    logic rst_q;

    // Power machine: async fault off, closed-loop return on current-off.
    always_ff @(posedge clk or posedge fault_i) begin
        if (fault_i) begin
            pwr_q <= 1'b0;
        end else if (!rst_n) begin
            pwr_q <= 1'b1;
        end else if (pwr_q) begin
            pwr_q <= !go_cycle_i;
        end else begin
            pwr_q <= !go_cycle_i && isoff_i;
        end
    end

    // Reset machine: one registered bit, only while powered, cycle dominates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b0;
        end else begin
            rst_q <= go_reset_i && pwr_q && !go_cycle_i && !fault_i;
        end
    end

    assign rst_o = rst_q;
    assign pwr_o = pwr_q;

endmodule

// File: rtl/voting_resolver.sv
// Top of the resolver: one decoder per requester, a shared tally, and one
// restart machine per processor, plus a registered not-voting flag.
// Assumes request codes are synchronous to clk.
module voting_resolver
    import resolver_pkg::*;
#(
    parameter int N_PROC   = 3,
    parameter int VOTE_MIN = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*N_PROC-1:0]   req_code_i,
    input  logic [2*N_PROC-1:0]   tgt_sel_i,
    input  logic [N_PROC-1:0]     overcur_i,
    input  logic [N_PROC-1:0]     curr_off_i,
    output logic [N_PROC-1:0]     proc_reset_o,
    output logic [N_PROC-1:0]     proc_power_o,
    output logic [N_PROC-1:0]     no_vote_o
);

    localparam int MAT_W = N_PROC * N_PROC;

    logic [MAT_W-1:0]  rst_now_m;
    logic [MAT_W-1:0]  cyc_now_m;
    logic [MAT_W-1:0]  rst_vote_m;
    logic [MAT_W-1:0]  cyc_vote_m;
    logic [N_PROC-1:0] go_reset;
    logic [N_PROC-1:0] go_cycle;
    logic [N_PROC-1:0] no_vote_q;

    for (genvar k = 0; k < N_PROC; k++) begin : g_req
        req_decoder #(
            .N_PROC (N_PROC),
            .IDX    (k)
        ) dec_i (
            .act_i      (req_code_i[2*k +: 2]),
            .tgt_i      (tgt_sel_i[2*k +: 2]),
            .rst_now_o  (rst_now_m[k*N_PROC +: N_PROC]),
            .cyc_now_o  (cyc_now_m[k*N_PROC +: N_PROC]),
            .rst_vote_o (rst_vote_m[k*N_PROC +: N_PROC]),
            .cyc_vote_o (cyc_vote_m[k*N_PROC +: N_PROC])
        );

        // Not-voting flag: registered decode of the offline code.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                no_vote_q[k] <= 1'b1;
            end else begin
                no_vote_q[k] <= (req_code_i[2*k +: 2] == ACT_OFFLINE);
            end
        end
    end

    vote_tally #(
        .N_PROC   (N_PROC),
        .VOTE_MIN (VOTE_MIN)
    ) tally_i (
        .rst_now_i  (rst_now_m),
        .cyc_now_i  (cyc_now_m),
        .rst_vote_i (rst_vote_m),
        .cyc_vote_i (cyc_vote_m),
        .go_reset_o (go_reset),
        .go_cycle_o (go_cycle)
    );

    for (genvar p = 0; p < N_PROC; p++) begin : g_proc
        proc_restart_fsm fsm_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .go_reset_i (go_reset[p]),
            .go_cycle_i (go_cycle[p]),
            .fault_i    (overcur_i[p]),
            .isoff_i    (curr_off_i[p]),
            .rst_o      (proc_reset_o[p]),
            .pwr_o      (proc_power_o[p])
        );
    end

    assign no_vote_o = no_vote_q;

endmodule

// File: rtl/resolver_checker.sv
// Cycle-level properties of the resolver, bound onto every instance.
// Assumes the grant vectors of the tally are visible as go_reset/go_cycle.
module resolver_checker #(
    parameter int N_PROC = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*N_PROC-1:0] req_code_i,
    input logic [N_PROC-1:0]   overcur_i,
    input logic [N_PROC-1:0]   curr_off_i,
    input logic [N_PROC-1:0]   proc_reset_o,
    input logic [N_PROC-1:0]   proc_power_o,
    input logic [N_PROC-1:0]   no_vote_o,
    input logic [N_PROC-1:0]   go_reset,
    input logic [N_PROC-1:0]   go_cycle
);

    for (genvar i = 0; i < N_PROC; i++) begin : g_chk
        // R9: a live fault always coincides with power removed.
        a_r9_fault_cuts_power: assert property (@(posedge clk) disable iff (!rst_n)
            overcur_i[i] |-> !proc_power_o[i]);

        // R8: power only returns after the current-off flag was seen.
        a_r8_power_needs_isoff: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(proc_power_o[i]) && $past(rst_n)) |-> $past(curr_off_i[i]));

        // R10: a processor kept off shows no reset.
        a_r10_no_reset_while_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!proc_power_o[i] && $past(!proc_power_o[i])) |-> !proc_reset_o[i]);

        // R7: reset only rises after a reset grant.
        a_r7_reset_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(proc_reset_o[i]) |-> $past(go_reset[i]));

        // R11: a cycle grant never leaves reset asserted.
        a_r11_cycle_beats_reset: assert property (@(posedge clk) disable iff (!rst_n)
            go_cycle[i] |=> !proc_reset_o[i]);

        // R1: the not-voting flag follows the previous action code.
        a_r1_offline_flag: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (no_vote_o[i] == ($past(req_code_i[2*i +: 2]) == 2'b00)));
    end

endmodule

bind voting_resolver resolver_checker #(.N_PROC(N_PROC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_code_i   (req_code_i),
    .overcur_i    (overcur_i),
    .curr_off_i   (curr_off_i),
    .proc_reset_o (proc_reset_o),
    .proc_power_o (proc_power_o),
    .no_vote_o    (no_vote_o),
    .go_reset     (go_reset),
    .go_cycle     (go_cycle)
);

// File: tb/voting_resolver_tb_top.sv
// Self-checking bench: vector table walk plus directed reset/fault cases.
module voting_resolver_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N = 3;

    // action codes
    localparam logic [1:0] O = 2'b00;   // offline
    localparam logic [1:0] I = 2'b11;   // idle online
    localparam logic [1:0] R = 2'b01;   // vote reset
    localparam logic [1:0] C = 2'b10;   // vote cycle
    // target codes
    localparam logic [1:0] S = 2'b00;   // self
    localparam logic [1:0] X = 2'b01;   // next peer
    localparam logic [1:0] P = 2'b10;   // both peers
    localparam logic [1:0] A = 2'b11;   // all

    // {tag[27:24], req p2,p1,p0 [23:18], sel p2,p1,p0 [17:12], isoff[11:9],
    //  exp_reset[8:6], exp_power[5:3], exp_novote[2:0]}
    localparam int NV = 23;
    localparam logic [27:0] VEC [NV] = '{
        {4'd13, I,I,I, S,S,S, 3'b000, 3'b000, 3'b111, 3'b000}, // R13 idle codes do nothing
        {4'd5,  I,I,R, S,S,X, 3'b000, 3'b000, 3'b111, 3'b000}, // R5 single vote
        {4'd6,  R,I,R, P,S,X, 3'b000, 3'b010, 3'b111, 3'b000}, // R6 two reset votes on P1
        {4'd7,  I,I,I, S,S,S, 3'b000, 3'b000, 3'b111, 3'b000}, // R7 reset ends
        {4'd5,  C,I,R, P,S,X, 3'b000, 3'b000, 3'b111, 3'b000}, // R5 mixed votes
        {4'd2,  I,R,I, S,A,S, 3'b000, 3'b111, 3'b111, 3'b000}, // R2 reset all
        {4'd1,  O,O,O, S,S,S, 3'b000, 3'b000, 3'b111, 3'b111}, // R1 offline flags
        {4'd1,  I,I,I, S,S,S, 3'b000, 3'b000, 3'b111, 3'b000}, // R1 back online
        {4'd3,  C,I,I, S,S,S, 3'b000, 3'b000, 3'b011, 3'b000}, // R3 cycle self P2
        {4'd8,  O,I,I, S,S,S, 3'b000, 3'b000, 3'b011, 3'b100}, // R8 waits for flag
        {4'd8,  O,I,I, S,S,S, 3'b100, 3'b000, 3'b111, 3'b100}, // R8 flag restores
        {4'd3,  I,I,C, S,S,S, 3'b001, 3'b000, 3'b110, 3'b000}, // R3 cycle self P0
        {4'd8,  I,I,C, S,S,S, 3'b001, 3'b000, 3'b110, 3'b000}, // R8 request still held
        {4'd8,  I,I,O, S,S,S, 3'b001, 3'b000, 3'b111, 3'b001}, // R8 restore
        {4'd3,  I,I,C, S,S,S, 3'b000, 3'b000, 3'b110, 3'b000}, // R3 P0 off again
        {4'd10, I,R,O, S,A,S, 3'b000, 3'b110, 3'b110, 3'b001}, // R10 off P0 not reset
        {4'd8,  I,I,I, S,S,S, 3'b001, 3'b000, 3'b111, 3'b000}, // R8 P0 back
        {4'd4,  R,I,I, S,S,S, 3'b000, 3'b000, 3'b000, 3'b000}, // R4 reset-self = cycle all
        {4'd8,  O,O,O, S,S,S, 3'b111, 3'b000, 3'b111, 3'b111}, // R8 all restore
        {4'd11, C,R,R, S,P,P, 3'b000, 3'b000, 3'b011, 3'b000}, // R11 cycle beats reset on P2
        {4'd8,  I,I,I, S,S,S, 3'b100, 3'b000, 3'b111, 3'b000}, // R8 P2 back
        {4'd6,  C,I,C, P,S,X, 3'b000, 3'b000, 3'b101, 3'b000}, // R6 two cycle votes on P1
        {4'd8,  I,I,I, S,S,S, 3'b010, 3'b000, 3'b111, 3'b000}  // R8 P1 back
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [2*N-1:0] req_code;
    logic [2*N-1:0] tgt_sel;
    logic [N-1:0] overcur;
    logic [N-1:0] curr_off;
    logic [N-1:0] proc_reset;
    logic [N-1:0] proc_power;
    logic [N-1:0] no_vote;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    voting_resolver #(.N_PROC(N), .VOTE_MIN(2)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_code_i   (req_code),
        .tgt_sel_i    (tgt_sel),
        .overcur_i    (overcur),
        .curr_off_i   (curr_off),
        .proc_reset_o (proc_reset),
        .proc_power_o (proc_power),
        .no_vote_o    (no_vote)
    );

    task automatic check(input string tag, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check3(input string tag, input logic [N-1:0] er,
                          input logic [N-1:0] ep, input logic [N-1:0] en);
        check(tag, "reset", proc_reset, er);
        check(tag, "power", proc_power, ep);
        check(tag, "novote", no_vote, en);
    endtask

    initial begin
        rst_n    = 1'b0;
        req_code = {O, O, O};
        tgt_sel  = {S, S, S};
        overcur  = '0;
        curr_off = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check3("R12", 3'b000, 3'b111, 3'b111);
        rst_n = 1'b1;

        // vector table
        for (int v = 0; v < NV; v++) begin
            req_code = VEC[v][23:18];
            tgt_sel  = VEC[v][17:12];
            curr_off = VEC[v][11:9];
            @(negedge clk);
            check3($sformatf("R%0d vec%0d", VEC[v][27:24], v),
                   VEC[v][8:6], VEC[v][5:3], VEC[v][2:0]);
        end

        // R7 reset held while requested, released one cycle later
        req_code = {I, R, I}; tgt_sel = {S, A, S}; curr_off = '0;
        @(negedge clk); check("R7", "reset", proc_reset, 3'b111);
        @(negedge clk); check("R7", "reset", proc_reset, 3'b111);
        req_code = {I, I, I}; tgt_sel = {S, S, S};
        @(negedge clk); check("R7", "reset", proc_reset, 3'b000);

        // R9 asynchronous fault
        overcur = 3'b010;
        #1;
        check("R9", "power", proc_power, 3'b101);
        curr_off = 3'b010;
        @(negedge clk); check("R9", "power", proc_power, 3'b101);
        overcur = 3'b000;
        @(negedge clk); check("R8", "power", proc_power, 3'b111);

        // R12 mid-run reset restores power and flags
        curr_off = '0;
        req_code = {I, C, I}; tgt_sel = {S, S, S};
        @(negedge clk); check("R3", "power", proc_power, 3'b101);
        rst_n = 1'b0; req_code = {O, O, O};
        @(negedge clk); check3("R12", 3'b000, 3'b111, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule